// File: doc/BRIEF.md
# Prioritized Interrupt Level Dispatcher

This block sits beside a processor core's control logic and decides, cycle by cycle, whether the pending interrupt level offered by the interrupt controller is taken. It compares the pending level with the current interrupt level in the status word. It also checks that level against the configured level count, and against the intersection of that level's source mask with the raw set and enable vectors. When the interrupt is accepted, the block updates the core's architectural state in a single clocked step.

Levels 2 and above vector directly. The interrupted PC and the old status go into save registers banked per level, the status takes the new level with exception mode set, and the PC output moves to the level's vector. That vector can optionally be relocated against a programmable base. Level 1 does not vector on its own. It records a fixed cause code and is turned into a user, kernel or double exception, chosen by the exception-mode and user-mode bits. The core's exception logic acts on the exception-class output.

Top module: `irq_level_dispatch`

## Requirements
- R1: After synchronous reset, every output is zero: pc_out, status_out, cause_out, the save registers, taken, and exc_class (0 = none).
- R2: An interrupt is taken only when pend_level is greater than status_in[3:0], and the mask of that level ANDed with int_set and int_en is nonzero. The mask of level L is level_mask[(L-1)*NUM_IRQ +: NUM_IRQ]. When no interrupt is taken, no state output changes.
- R3: For a taken level L of 2 or above, pc_in is stored in PC save bank L and status_in in status save bank L. Bank L sits at epc_bank/eps_bank bits [(L-2)*32 +: 32]. Other banks keep their values.
- R4: For a taken level L of 2 or above, status_out becomes status_in with bits 3:0 replaced by L and bit 4 (exception mode) set. pc_out becomes the vector of L.
- R5: The vector of level L is VEC_DEFAULT_BASE + L*VEC_STRIDE. When reloc_en is high, it is that value minus VEC_DEFAULT_BASE plus vecbase_in.
- R6: A taken level-1 interrupt writes L1_CAUSE (default 4) into cause_out and sets status bit 4, leaving the other status bits as in status_in. pc_out is not changed.
- R7: A taken level-1 interrupt while status_in bit 4 is set gives exc_class 3 (double). pc_in goes to depc_out when HAS_DEPC is 1, otherwise to epc1_out. With HAS_DEPC = 1, epc1_out is unchanged.
- R8: A taken level-1 interrupt while status_in bit 4 is clear stores pc_in in epc1_out. It gives exc_class 1 (user) if status_in bit 5 is set, otherwise 2 (kernel).
- R9: taken is high for exactly the cycle after each accepted interrupt, so back-to-back dispatches keep it high. exc_class is 0 in every cycle that does not follow a level-1 dispatch.
- R10: A pending level above NUM_LEVELS is never taken, whatever the set and enable vectors hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pend_level | input | 4 | Highest pending interrupt level |
| int_set | input | NUM_IRQ | Raw interrupt set vector |
| int_en | input | NUM_IRQ | Interrupt enable vector |
| level_mask | input | NUM_LEVELS*NUM_IRQ | Per-level source mask table, level 1 lowest slice |
| status_in | input | 32 | Current status word |
| pc_in | input | PC_W | Current PC |
| reloc_en | input | 1 | Vector relocation enable |
| vecbase_in | input | PC_W | Programmable vector base |
| pc_out | output | PC_W | New PC after a high-level dispatch |
| status_out | output | 32 | Status word after dispatch |
| cause_out | output | CAUSE_W | Exception cause register |
| exc_class | output | 2 | Exception class select: 0 none, 1 user, 2 kernel, 3 double |
| taken | output | 1 | One-cycle dispatch strobe |
| epc1_out | output | PC_W | Level-1 PC save register |
| depc_out | output | PC_W | Double-exception PC save register |
| epc_bank | output | (NUM_LEVELS-1)*PC_W | PC save banks for levels 2 and above |
| eps_bank | output | (NUM_LEVELS-1)*32 | Status save banks for levels 2 and above |

## Verification
The assertions assume that status_in, pend_level and the vectors are stable around each rising edge. The $past-based checks relate a registered result to the inputs of the cycle before, and only hold under that assumption. The bench therefore changes every input on the falling edge only. It also keeps the status interrupt-level field within the 4-bit range that the level comparison uses. Each stimulus pattern is held for exactly one edge, which lets the reference model pair every output change with a single set of inputs.

// File: rtl/irqd_pkg.sv
package irqd_pkg;
  localparam int LVL_W   = 4;
  localparam int ST_W    = 32;
  localparam int ST_EXCM = 4;
  localparam int ST_UM   = 5;

  typedef enum logic [1:0] {
    XC_NONE   = 2'd0,
    XC_USER   = 2'd1,
    XC_KERNEL = 2'd2,
    XC_DOUBLE = 2'd3
  } xclass_e;
endpackage

// File: rtl/irqd_qualify.sv
module irqd_qualify
  import irqd_pkg::*;
#(
  parameter int NUM_IRQ    = 8,
  parameter int NUM_LEVELS = 7
) (
  input  logic [LVL_W-1:0]              pend_level,
  input  logic [LVL_W-1:0]              cur_level,
  input  logic [NUM_IRQ-1:0]            int_set,
  input  logic [NUM_IRQ-1:0]            int_en,
  input  logic [NUM_LEVELS*NUM_IRQ-1:0] level_mask,
  output logic                          fire
);
  logic [NUM_IRQ-1:0] sel_mask;

  // one-hot compare per level; an unmatched level selects an empty mask
  always_comb begin
    sel_mask = '0;
    for (int l = 1; l <= NUM_LEVELS; l++) begin
      if (pend_level == LVL_W'(l))
        sel_mask = level_mask[(l-1)*NUM_IRQ +: NUM_IRQ];
    end
  end

  assign fire = (pend_level > cur_level) &&
                (pend_level <= LVL_W'(NUM_LEVELS)) &&
                (|(sel_mask & int_set & int_en));
endmodule

// File: rtl/irqd_vector.sv
module irqd_vector
  import irqd_pkg::*;
#(
  parameter int              PC_W             = 32,
  parameter logic [PC_W-1:0] VEC_DEFAULT_BASE = 32'h2000_0000,
  parameter logic [PC_W-1:0] VEC_STRIDE       = 32'h0000_0040
) (
  input  logic [LVL_W-1:0] level,
  input  logic             reloc_en,
  input  logic [PC_W-1:0]  vecbase_in,
  output logic [PC_W-1:0]  target
);
  logic [PC_W-1:0] dflt;

  assign dflt   = VEC_DEFAULT_BASE + PC_W'(level) * VEC_STRIDE;
  assign target = reloc_en ? (dflt - VEC_DEFAULT_BASE + vecbase_in) : dflt;
endmodule

// File: rtl/irq_level_dispatch.sv
module irq_level_dispatch
  import irqd_pkg::*;
#(
  parameter int              NUM_IRQ          = 8,
  parameter int              NUM_LEVELS       = 7,
  parameter int              PC_W             = 32,
  parameter int              CAUSE_W          = 6,
  parameter int              L1_CAUSE         = 4,
  parameter bit              HAS_DEPC         = 1'b1,
  parameter logic [PC_W-1:0] VEC_DEFAULT_BASE = 32'h2000_0000,
  parameter logic [PC_W-1:0] VEC_STRIDE       = 32'h0000_0040
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic [LVL_W-1:0]                    pend_level,
  input  logic [NUM_IRQ-1:0]                  int_set,
  input  logic [NUM_IRQ-1:0]                  int_en,
  input  logic [NUM_LEVELS*NUM_IRQ-1:0]       level_mask,
  input  logic [ST_W-1:0]                     status_in,
  input  logic [PC_W-1:0]                     pc_in,
  input  logic                                reloc_en,
  input  logic [PC_W-1:0]                     vecbase_in,
  output logic [PC_W-1:0]                     pc_out,
  output logic [ST_W-1:0]                     status_out,
  output logic [CAUSE_W-1:0]                  cause_out,
  output logic [1:0]                          exc_class,
  output logic                                taken,
  output logic [PC_W-1:0]                     epc1_out,
  output logic [PC_W-1:0]                     depc_out,
  output logic [(NUM_LEVELS-1)*PC_W-1:0]      epc_bank,
  output logic [(NUM_LEVELS-1)*ST_W-1:0]      eps_bank
);
  localparam int NBANK = NUM_LEVELS - 1;

  logic            fire;
  logic            is_l1;
  logic            in_excm;
  logic [PC_W-1:0] vec_target;

  logic [PC_W-1:0]    pc_q;
  logic [ST_W-1:0]    status_q;
  logic [CAUSE_W-1:0] cause_q;
  xclass_e            class_q;
  logic               taken_q;
  logic [PC_W-1:0]    epc1_q;

  irqd_qualify #(.NUM_IRQ(NUM_IRQ), .NUM_LEVELS(NUM_LEVELS)) u_qual (
    .pend_level (pend_level),
    .cur_level  (status_in[LVL_W-1:0]),
    .int_set    (int_set),
    .int_en     (int_en),
    .level_mask (level_mask),
    .fire       (fire)
  );

  irqd_vector #(.PC_W(PC_W), .VEC_DEFAULT_BASE(VEC_DEFAULT_BASE),
                .VEC_STRIDE(VEC_STRIDE)) u_vec (
    .level      (pend_level),
    .reloc_en   (reloc_en),
    .vecbase_in (vecbase_in),
    .target     (vec_target)
  );

  assign is_l1   = (pend_level == LVL_W'(1));
  assign in_excm = status_in[ST_EXCM];

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q     <= '0;
      status_q <= '0;
      cause_q  <= '0;
      class_q  <= XC_NONE;
      taken_q  <= 1'b0;
      epc1_q   <= '0;
    end else begin
      taken_q <= fire;
      class_q <= XC_NONE;
      if (fire) begin
        if (is_l1) begin
          cause_q  <= CAUSE_W'(L1_CAUSE);
          status_q <= status_in | (ST_W'(1) << ST_EXCM);
          if (in_excm) begin
            class_q <= XC_DOUBLE;
            if (!HAS_DEPC) epc1_q <= pc_in;
          end else begin
            epc1_q  <= pc_in;
            class_q <= status_in[ST_UM] ? XC_USER : XC_KERNEL;
          end
        end else begin
          status_q <= {status_in[ST_W-1:ST_EXCM+1], 1'b1, pend_level};
          pc_q     <= vec_target;
        end
      end
    end
  end

  // banked save registers, one pair per level from 2 upward
  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic [PC_W-1:0] epc_q;
    logic [ST_W-1:0] eps_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        epc_q <= '0;
        eps_q <= '0;
      end else if (fire && pend_level == LVL_W'(b + 2)) begin
        epc_q <= pc_in;
        eps_q <= status_in;
      end
    end
    assign epc_bank[b*PC_W +: PC_W] = epc_q;
    assign eps_bank[b*ST_W +: ST_W] = eps_q;
  end

  if (HAS_DEPC) begin : g_depc
    logic [PC_W-1:0] depc_q;
    always_ff @(posedge clk) begin
      if (rst)                           depc_q <= '0;
      else if (fire && is_l1 && in_excm) depc_q <= pc_in;
    end
    assign depc_out = depc_q;
  end else begin : g_no_depc
    assign depc_out = '0;
  end

  assign pc_out     = pc_q;
  assign status_out = status_q;
  assign cause_out  = cause_q;
  assign exc_class  = class_q;
  assign taken      = taken_q;
  assign epc1_out   = epc1_q;

  // R2: status changes only on a dispatch
  p_hold_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !taken |-> $stable(status_out));
  // R4: a high-level dispatch raised the interrupt level above the old one
  p_level_raise_r4: assert property (@(posedge clk) disable iff (rst)
    (taken && exc_class == 2'd0) |-> (status_out[3:0] > $past(status_in[3:0])));
  // R6: every dispatch leaves exception mode set
  p_excm_set_r6: assert property (@(posedge clk) disable iff (rst)
    taken |-> status_out[ST_EXCM]);
  // R9: a class select only accompanies the strobe
  p_class_strobe_r9: assert property (@(posedge clk) disable iff (rst)
    (exc_class != 2'd0) |-> taken);
  // R6: a level-1 dispatch carries the level-1 cause
  p_l1_cause_r6: assert property (@(posedge clk) disable iff (rst)
    (exc_class != 2'd0) |-> (cause_out == CAUSE_W'(L1_CAUSE)));
  // R10: a level out of range never dispatches
  p_range_r10: assert property (@(posedge clk) disable iff (rst)
    (pend_level > LVL_W'(NUM_LEVELS)) |=> !taken);
endmodule

// File: tb/test_irq_level_dispatch.sv
module test_irq_level_dispatch;
  localparam int NI = 8;
  localparam int NL = 7;
  localparam logic [31:0] DEFB = 32'h2000_0000;
  localparam logic [31:0] STR  = 32'h0000_0040;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] pend_level = '0;
  logic [NI-1:0] int_set = '0, int_en = '0;
  logic [NL*NI-1:0] level_mask;
  logic [31:0] status_in = '0, pc_in = '0, vecbase_in = '0;
  logic reloc_en = 1'b0;
  logic [31:0] pc_out, status_out, epc1_out, depc_out;
  logic [5:0] cause_out;
  logic [1:0] exc_class;
  logic taken;
  logic [(NL-1)*32-1:0] epc_bank, eps_bank;

  always #2.5 clk = ~clk;

  irq_level_dispatch i_irq_level_dispatch (
    .clk(clk), .rst(rst), .pend_level(pend_level), .int_set(int_set),
    .int_en(int_en), .level_mask(level_mask), .status_in(status_in),
    .pc_in(pc_in), .reloc_en(reloc_en), .vecbase_in(vecbase_in),
    .pc_out(pc_out), .status_out(status_out), .cause_out(cause_out),
    .exc_class(exc_class), .taken(taken), .epc1_out(epc1_out),
    .depc_out(depc_out), .epc_bank(epc_bank), .eps_bank(eps_bank));

  int total = 0, bad = 0;
  bit done = 0;

  // behavioural reference state
  logic [31:0] m_pc = 0, m_st = 0, m_epc1 = 0, m_depc = 0;
  int m_cause = 0, m_class = 0;
  bit m_taken = 0;
  logic [31:0] m_epc [2:NL];
  logic [31:0] m_eps [2:NL];

  task automatic cmp(string tag, string nm, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, nm, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    cmp(tag, "pc_out", pc_out, m_pc);
    cmp(tag, "status_out", status_out, m_st);
    cmp(tag, "cause_out", cause_out, m_cause);
    cmp(tag, "exc_class", exc_class, m_class);
    cmp(tag, "taken", taken, m_taken);
    cmp(tag, "epc1_out", epc1_out, m_epc1);
    cmp(tag, "depc_out", depc_out, m_depc);
    for (int l = 2; l <= NL; l++) begin
      cmp(tag, "epc_bank", epc_bank[(l-2)*32 +: 32], m_epc[l]);
      cmp(tag, "eps_bank", eps_bank[(l-2)*32 +: 32], m_eps[l]);
    end
  endtask

  task automatic model_edge();
    int pl;
    int cur;
    logic [NI-1:0] msk;
    bit ok;
    logic [31:0] vec;
    pl  = int'(pend_level);
    cur = int'(status_in[3:0]);
    msk = '0;
    if (pl >= 1 && pl <= NL) msk = level_mask[(pl-1)*NI +: NI];
    ok = (pl > cur) && (pl <= NL) && ((msk & int_set & int_en) != 0);
    m_taken = ok;
    m_class = 0;
    if (!ok) return;
    if (pl == 1) begin
      m_cause = 4;
      m_st = status_in | 32'h10;
      if (status_in[4]) begin
        m_class = 3;
        m_depc = pc_in;
      end else begin
        m_epc1 = pc_in;
        m_class = status_in[5] ? 1 : 2;
      end
    end else begin
      m_epc[pl] = pc_in;
      m_eps[pl] = status_in;
      m_st = {status_in[31:5], 1'b1, 4'(pl)};
      vec = DEFB + 32'(pl) * STR;
      m_pc = reloc_en ? vec - DEFB + vecbase_in : vec;
    end
  endtask

  task automatic step(string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check_all(tag);
  endtask

  task automatic drive(int lvl, logic [7:0] s, logic [7:0] e,
                       logic [31:0] st, logic [31:0] pc);
    pend_level = 4'(lvl);
    int_set = s;
    int_en = e;
    status_in = st;
    pc_in = pc;
  endtask

  initial begin
    // level L owns source bit L (level 7 also owns bit 0)
    for (int l = 1; l <= NL; l++) begin
      level_mask[(l-1)*NI +: NI] = 8'(1 << l) | ((l == 7) ? 8'h01 : 8'h00);
    end
    for (int l = 2; l <= NL; l++) begin
      m_epc[l] = 0;
      m_eps[l] = 0;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check_all("R1");

    drive(3, 8'h08, 8'hFF, 32'h0, 32'h0000_1000);
    step("R3");                                           // R4 R5 default vector
    drive(0, 8'h00, 8'h00, 32'h13, 32'h0000_1004);
    step("R9");                                           // strobe falls
    drive(3, 8'hFF, 8'hFF, 32'h3, 32'h0000_1008);
    step("R2");                                           // equal level ignored
    drive(5, 8'h20, 8'hDF, 32'h0, 32'h0000_100C);
    step("R2");                                           // disabled source
    drive(2, 8'h08, 8'hFF, 32'h0, 32'h0000_100C);
    step("R2");                                           // source of other level
    drive(9, 8'hFF, 8'hFF, 32'h0, 32'h0000_1010);
    step("R10");
    drive(8, 8'hFF, 8'hFF, 32'h0, 32'h0000_1010);
    step("R10");
    reloc_en = 1'b1;
    vecbase_in = 32'h8000_0000;
    drive(7, 8'h01, 8'h01, 32'h0000_0102, 32'h0000_2000);
    step("R5");                                           // R4 keeps upper bits
    reloc_en = 1'b0;
    drive(1, 8'h02, 8'h02, 32'h0000_0200, 32'h0000_3000);
    step("R8");                                           // kernel, R6 cause
    drive(1, 8'h02, 8'h02, 32'h0000_0020, 32'h0000_3100);
    step("R8");                                           // user
    drive(1, 8'h02, 8'h02, 32'h0000_0030, 32'h0000_3200);
    step("R7");                                           // double, epc1 kept
    drive(1, 8'h02, 8'h02, 32'h0000_0001, 32'h0000_3300);
    step("R2");                                           // level 1 at level 1
    drive(2, 8'h04, 8'h04, 32'h0000_0001, 32'h0000_4000);
    step("R2");                                           // one above current
    drive(4, 8'h10, 8'h10, 32'h0000_0012, 32'h0000_4100);
    step("R9");                                           // back to back
    drive(1, 8'h02, 8'h02, 32'h0, 32'h0000_4200);
    step("R9");                                           // class after high level
    drive(0, 8'h00, 8'h00, 32'h0, 32'h0);
    step("R9");
    step("R3");                                           // banks retained
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    m_pc = 0; m_st = 0; m_epc1 = 0; m_depc = 0;
    m_cause = 0; m_class = 0; m_taken = 0;
    for (int l = 2; l <= NL; l++) begin
      m_epc[l] = 0;
      m_eps[l] = 0;
    end
    check_all("R1");
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule